// File: doc/BRIEF.md
# Variable-Region Central Address Decoder

This block sits between the masters of a shared bus and its slaves. It takes the address, an active-low address-valid strobe and the read/write line. It raises exactly one enable for the slave whose region holds the address. If no region holds the address, it raises a no-slave flag instead. Each slave owns a region whose size is a power of two, from a single location up to most of the address space. Each region's base is aligned to its own size, so only the address bits above the region size take part in the compare.

Base and size of every region are parameters. If two regions collide or a base is misaligned, elaboration stops. The path from inputs to outputs is purely combinational.

The read/write level is passed on as two qualified strobes, read and write. Each is active only while some slave is selected. While the strobe is deasserted, every output is inactive.

The default map, on a 16-bit address, has four regions:

- Slave 0: 0x0000–0x7FFF (32K locations)
- Slave 1: 0x8000–0x8FFF (4K locations)
- Slave 2: 0xF000–0xF001 (two locations)
- Slave 3: 0xF002 (one location)

Top module: `addr_region_decoder`

## Requirements
- R1: With the strobe asserted (addr_valid_n_i = 0), slave_sel_o[i] is 1 exactly when base_i <= addr_i <= base_i + 2^log2_i - 1. In the default map these bounds are 0x0000–0x7FFF, 0x8000–0x8FFF, 0xF000–0xF001 and 0xF002–0xF002.
- R2: A region of size one (log2 = 0) responds to its single address only. Its neighbours one below and one above do not select it.
- R3: At most one bit of slave_sel_o is 1 for any input.
- R4: While addr_valid_n_i = 1, slave_sel_o, no_slave_o, read_o and write_o are all 0, whatever the address and read/write level.
- R5: no_slave_o is 1 exactly when the strobe is asserted and the address lies in no region. Whenever it is 1, slave_sel_o is all zero.
- R6: read_o is 1 when a slave is selected and rd_wr_i = 1 (read). write_o is 1 when a slave is selected and rd_wr_i = 0 (write). Both are 0 when no slave is selected.
- R7: Outputs follow input changes with no clock edge, without registering.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| addr_i | input | ADDR_W (16) | Bus address |
| addr_valid_n_i | input | 1 | Address-valid strobe, active low |
| rd_wr_i | input | 1 | 1 = read, 0 = write |
| slave_sel_o | output | NUM_SLAVES (4) | One-hot slave enables |
| no_slave_o | output | 1 | Valid address hits no region |
| read_o | output | 1 | Qualified read strobe to the selected slave |
| write_o | output | 1 | Qualified write strobe to the selected slave |

## Verification
The whole 64K address space is swept with the strobe asserted and the read/write level alternating. Every address is compared against bounds computed in the bench. This separates a wrong compare width, which would misplace region edges, from a wrong base, which would shift a whole region. A second sweep with the strobe deasserted shows that gating covers every output. Explicit first, last and one-outside addresses of each region catch off-by-one edges, with the single-location region and the gaps at 0x9000 and 0xF003 as the sharpest cases. A mid-cycle address change confirms the path holds no register.

// File: rtl/addr_dec_pkg.sv
package addr_dec_pkg;

    localparam int unsigned MAX_AW = 64;

    typedef struct packed {
        logic read;
        logic write;
    } bus_strobe_t;

    // two aligned power-of-two regions collide when their bases agree
    // above the larger of the two sizes
    function automatic bit regions_collide(
        input logic [MAX_AW-1:0] base_a,
        input int unsigned       log_a,
        input logic [MAX_AW-1:0] base_b,
        input int unsigned       log_b
    );
        int unsigned span;
        span = (log_a > log_b) ? log_a : log_b;
        return (base_a >> span) == (base_b >> span);
    endfunction

    function automatic bit base_misaligned(
        input logic [MAX_AW-1:0] base,
        input int unsigned       log_sz
    );
        logic [MAX_AW-1:0] low_mask;
        low_mask = (log_sz >= MAX_AW) ? '1 : ((64'd1 << log_sz) - 64'd1);
        return (base & low_mask) != '0;
    endfunction

endpackage

// File: rtl/region_match.sv
module region_match #(
    parameter int unsigned           ADDR_W = 16,
    parameter logic [ADDR_W-1:0]     BASE   = '0,
    parameter int unsigned           LOG2   = 0
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic              hit_o
);
    generate
        if (LOG2 >= ADDR_W) begin : g_whole
            logic unused_addr;
            assign unused_addr = ^addr_i;
            assign hit_o = 1'b1;
        end else begin : g_cmp
            localparam int unsigned TOP_W = ADDR_W - LOG2;
            logic [TOP_W-1:0] tag;
            assign tag   = addr_i[ADDR_W-1:LOG2];
            assign hit_o = (tag == BASE[ADDR_W-1:LOG2]);
        end
    endgenerate
endmodule

// File: rtl/sel_gate.sv
module sel_gate
    import addr_dec_pkg::*;
#(
    parameter int unsigned NUM_SLAVES = 4
) (
    input  logic [NUM_SLAVES-1:0] hits_i,
    input  logic                  addr_valid_n_i,
    input  logic                  rd_wr_i,
    output logic [NUM_SLAVES-1:0] sel_o,
    output logic                  no_slave_o,
    output bus_strobe_t           strobe_o
);
    logic any_hit;

    always_comb begin
        any_hit    = |hits_i;
        sel_o      = addr_valid_n_i ? '0 : hits_i;
        no_slave_o = ~addr_valid_n_i & ~any_hit;
        strobe_o.read  = ~addr_valid_n_i & any_hit & rd_wr_i;
        strobe_o.write = ~addr_valid_n_i & any_hit & ~rd_wr_i;
    end

    always_comb begin
        // R3
        onehot_sel_chk: assert ($onehot0(hits_i));
        // R4
        idle_quiet_chk: assert (!addr_valid_n_i ||
            (sel_o == '0 && !no_slave_o && !strobe_o.read && !strobe_o.write));
        // R5
        miss_no_sel_chk: assert (!no_slave_o || sel_o == '0);
        // R6
        strobe_excl_chk: assert (!(strobe_o.read && strobe_o.write));
        // R6
        strobe_needs_sel_chk: assert (!(strobe_o.read || strobe_o.write) || sel_o != '0);
    end
endmodule

// File: rtl/addr_region_decoder.sv
module addr_region_decoder
    import addr_dec_pkg::*;
#(
    parameter int unsigned ADDR_W     = 16,
    parameter int unsigned NUM_SLAVES = 4,
    parameter logic [NUM_SLAVES-1:0][ADDR_W-1:0] REGION_BASE =
        {16'hF002, 16'hF000, 16'h8000, 16'h0000},
    parameter logic [NUM_SLAVES-1:0][7:0] REGION_LOG2 =
        {8'd0, 8'd1, 8'd12, 8'd15}
) (
    input  logic [ADDR_W-1:0]     addr_i,
    input  logic                  addr_valid_n_i,
    input  logic                  rd_wr_i,
    output logic [NUM_SLAVES-1:0] slave_sel_o,
    output logic                  no_slave_o,
    output logic                  read_o,
    output logic                  write_o
);
    logic [NUM_SLAVES-1:0] hits;
    bus_strobe_t           strobe;

    generate
        for (genvar i = 0; i < NUM_SLAVES; i++) begin : g_region
            if (base_misaligned(MAX_AW'(REGION_BASE[i]), int'(REGION_LOG2[i]))) begin : g_misaligned
                $error("region %0d base not aligned to its size", i);
            end
            for (genvar j = i + 1; j < NUM_SLAVES; j++) begin : g_pair
                if (regions_collide(MAX_AW'(REGION_BASE[i]), int'(REGION_LOG2[i]),
                                    MAX_AW'(REGION_BASE[j]), int'(REGION_LOG2[j]))) begin : g_overlap
                    $error("regions %0d and %0d overlap", i, j);
                end
            end
            region_match #(
                .ADDR_W (ADDR_W),
                .BASE   (REGION_BASE[i]),
                .LOG2   (int'(REGION_LOG2[i]))
            ) i_match (
                .addr_i (addr_i),
                .hit_o  (hits[i])
            );
        end
    endgenerate

    sel_gate #(
        .NUM_SLAVES (NUM_SLAVES)
    ) i_gate (
        .hits_i         (hits),
        .addr_valid_n_i (addr_valid_n_i),
        .rd_wr_i        (rd_wr_i),
        .sel_o          (slave_sel_o),
        .no_slave_o     (no_slave_o),
        .strobe_o       (strobe)
    );

    assign read_o  = strobe.read;
    assign write_o = strobe.write;

    always_comb begin
        // R3
        port_onehot_chk: assert ($onehot0(slave_sel_o));
        // R5
        flag_vs_sel_chk: assert (addr_valid_n_i || (no_slave_o != (slave_sel_o != '0)));
    end
endmodule

// File: tb/test_addr_region_decoder.sv
module test_addr_region_decoder;
    localparam int NS = 4;
    localparam int LO [NS] = '{32'h0000, 32'h8000, 32'hF000, 32'hF002};
    localparam int HI [NS] = '{32'h7FFF, 32'h8FFF, 32'hF001, 32'hF002};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] addr = '0;
    logic        vld_n = 1'b1;
    logic        rw = 1'b1;
    logic [NS-1:0] sel;
    logic        nos, rd, wr;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 0;

    addr_region_decoder i_addr_region_decoder (
        .addr_i         (addr),
        .addr_valid_n_i (vld_n),
        .rd_wr_i        (rw),
        .slave_sel_o    (sel),
        .no_slave_o     (nos),
        .read_o         (rd),
        .write_o        (wr)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 2) rst <= 1'b0;
        if (cyc >= 150000 && !done) begin
            fails = fails + 1;
            checks = checks + 1;
            $display("FAIL watchdog: run did not finish (cycles=%0d expected<150000)", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    function automatic logic [NS-1:0] exp_sel(input int a, input bit v_n);
        logic [NS-1:0] r = '0;
        if (!v_n)
            for (int k = 0; k < NS; k++)
                if (a >= LO[k] && a <= HI[k]) r[k] = 1'b1;
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s addr=%h: actual=%h expected=%h", req, addr, act, exp);
        end
    endtask

    // full output vector: {sel, nos, rd, wr}
    task automatic check_all(input string req);
        logic [NS-1:0] es;
        logic [NS+2:0] act, exp;
        es  = exp_sel(int'(addr), vld_n);
        exp = {es, (!vld_n && es == '0), (es != '0 && rw), (es != '0 && !rw)};
        act = {sel, nos, rd, wr};
        check(act == exp, req, 32'(act), 32'(exp));
    endtask

    task automatic apply(input int a, input bit v_n, input bit r);
        addr = a[15:0]; vld_n = v_n; rw = r;
        #1;
    endtask

    initial begin
        #5;
        // quiet state with strobe inactive (R4)
        check({sel, nos, rd, wr} == '0, "R4 initial", 32'({sel, nos, rd, wr}), 0);
        @(negedge rst); #3;

        // R1 R5 R6: exhaustive sweep, strobe asserted, alternating direction
        for (int a = 0; a < 65536; a++) begin
            apply(a, 1'b0, a[0]);
            check_all("R1/R5/R6 sweep");
            // R3
            check($countones(sel) <= 1, "R3 onehot", 32'(sel), 0);
        end

        // R4: strobe deasserted over a strided sweep
        for (int a = 0; a < 65536; a += 7) begin
            apply(a, 1'b1, a[1]);
            check({sel, nos, rd, wr} == '0, "R4 gated", 32'({sel, nos, rd, wr}), 0);
        end

        // R1 boundaries: first, last, and one past each region
        for (int k = 0; k < NS; k++) begin
            apply(LO[k], 1'b0, 1'b1);
            check(sel == (NS'(1) << k), "R1 first", 32'(sel), 32'(1 << k));
            apply(HI[k], 1'b0, 1'b0);
            check(sel == (NS'(1) << k) && wr && !rd, "R1/R6 last", 32'({sel, rd, wr}), 32'({NS'(1) << k, 2'b01}));
        end
        apply(32'h9000, 1'b0, 1'b1);
        check(nos && sel == '0 && !rd, "R5 gap 9000", 32'({sel, nos}), 32'h1);
        apply(32'hF003, 1'b0, 1'b0);
        check(nos && sel == '0 && !wr, "R5 gap F003", 32'({sel, nos}), 32'h1);

        // R2: single-location region and its neighbours
        apply(32'hF002, 1'b0, 1'b1);
        check(sel == 4'b1000, "R2 exact", 32'(sel), 32'h8);
        apply(32'hF001, 1'b0, 1'b1);
        check(sel[3] == 1'b0, "R2 below", 32'(sel), 32'h4);
        apply(32'hF003, 1'b0, 1'b1);
        check(sel[3] == 1'b0, "R2 above", 32'(sel), 0);

        // R7: change mid-cycle, away from any edge, outputs follow at once
        @(posedge clk); #5;
        addr = 16'h8000; vld_n = 1'b0; rw = 1'b1; #1;
        check(sel == 4'b0010 && rd, "R7 follow", 32'({sel, rd}), 32'h5);
        addr = 16'h0123; #1;
        check(sel == 4'b0001 && rd, "R7 follow2", 32'({sel, rd}), 32'h3);
        vld_n = 1'b1; #1;
        check({sel, nos, rd, wr} == '0, "R7/R4 release", 32'({sel, nos, rd, wr}), 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule